// File: doc/BRIEF.md
# Half-Duplex Three-Wire Serial Master

This block is a serial bus master for a three-wire clocked serial bus (serial clock, data out, data in) with four chip-select lines. A host programs it through a small 16-bit register bus. The host writes a transmit word and then a command word. The command names a chip select, says whether that select is asserted, and gives two separate bit counts. The block first shifts out the transmit bits. It then samples the receive bits. Data moves in one direction at a time.

Each chip select keeps its own six-bit setting: the edge on which data is sampled, the edge on which data is driven, the select polarity and a second-stage clock divide. The active setting is captured when a transfer starts. A further register picks the idle level of the serial clock. The base rate of the serial clock comes from `tickEn`, a one-cycle enable pulse made by a divider outside the block.

Register indices: 0 is data (writes load the transmit word, reads return the receive word), 1 is control/status, 2 holds the settings of selects 0 and 1, 3 holds the settings of selects 2 and 3, and 4 holds the clock inversion.

Top module: `uwire_master`

## Requirements
- R1: After reset, the status register reads 0, every chip-select output is at its deasserted level (all ones with the reset polarity), the serial clock is 0 and index 4 reads 0.
- R2: Index 2 holds select 0 in bits 5:0 and select 1 in bits 11:6. Index 3 holds selects 2 and 3 in the same way. Both read back with bits 15:12 zero. A control write without start reads back at index 1 as bit 12 assert, bits 11:10 select index, bits 9:5 transmit count and bits 4:0 receive count.
- R3: The transmit count comes from control bits 9:5. The transmit word is sent MSB-first starting at bit 15, so an N-bit value is sent when it is left-justified.
- R4: The receive count comes from control bits 4:0. Received bits shift in so that the last sampled bit lands in bit 0. An N-bit read returns the value right-justified, with zeros above it.
- R5: In a select's setting, bit 0 set samples data in on the falling clock edge (clear: rising), and bit 1 set changes data out on the rising edge (clear: falling). These are absolute edge directions and hold for either clock idle level.
- R6: Setting bits 4:3 give codes 0, 1 and 2. These hold each serial clock level for 1, 2 and 4 `tickEn` pulses (code 3 acts as 2). A transfer of T+R bits spans exactly 2(T+R) clock edges.
- R7: Bit 0 of index 4 sets the serial clock idle level.
- R8: With control bit 12 set, the select named by bits 11:10 is asserted. A control write with bit 12 clear deasserts it. Setting bit 2 set makes that select active high (clear: active low).
- R9: Status bit 14 (busy) reads 1 from the cycle after an accepted start (bit 13) until the last clock edge. While busy, any control write is ignored as a whole.
- R10: Status bit 15 is set when a read completes and is cleared by reading index 0.
- R11: A start with both counts zero leaves busy clear and produces no clock edge. The select fields still take effect.
- R12: With both counts nonzero, all transmit bits are sent first and the receive bits follow on the same select. A count above 16 is treated as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Base-rate enable pulse from the external divider |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (clears ready on index 0) |
| busAddr | input | 3 | Register index |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational from the index |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| csOut | output | 4 | Chip-select lines, polarity per select |

## Verification
The bench builds the block with its default sizing of four selects and 16-bit words. This size makes a full sweep practical. It covers every bit count from 1 to 16 in both directions, all four edge combinations, both clock idle levels and all three divide codes, spread over all four selects. A serial slave model in the bench captures the driven bits and supplies known receive patterns. The bench checks exact busy duration and edge counts against the arithmetic 2(T+R)·H. It also covers the combined transmit-then-receive transfer, count clamping, zero-count starts, ignored commands while busy and a sparse `tickEn`.

// File: rtl/uwire_pkg.sv
package uwire_pkg;
  localparam int UW_DW   = 16;
  localparam int UW_NCS  = 4;
  localparam int UW_CNTW = 5;
  localparam int UW_CSW  = $clog2(UW_NCS);
  localparam int UW_AW   = 3;
  localparam int UW_CFG_REGS = UW_NCS / 2;

  localparam logic [UW_AW-1:0] A_DATA = 3'd0;
  localparam logic [UW_AW-1:0] A_CTRL = 3'd1;
  localparam logic [UW_AW-1:0] A_CFG0 = 3'd2;
  localparam logic [UW_AW-1:0] A_CLK  = UW_AW'(2 + UW_CFG_REGS);

  localparam int B_RDY    = 15;
  localparam int B_BUSY   = 14;
  localparam int B_START  = 13;
  localparam int B_ASSERT = 12;

  // Six-bit per-select setting
  typedef struct packed {
    logic       checkRdy;
    logic [1:0] divCode;
    logic       csHigh;
    logic       driveRise;
    logic       sampleFall;
  } csCfg_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic loadTx;
    logic preload;
    logic driveBit;
    logic sampleBit;
    logic clkToggle;
    logic rxClear;
  } uwStrobe_t;

  typedef enum logic [1:0] {PH_IDLE, PH_TX, PH_RX} phase_t;
endpackage

// File: rtl/uwire_dp.sv
module uwire_dp
  import uwire_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  uwStrobe_t        strobe,
  input  logic             txWrite,
  input  logic [UW_DW-1:0] txWdata,
  input  logic             idleLevel,
  input  logic             busy,
  input  logic             sdi,
  output logic             sclk,
  output logic             sdo,
  output logic [UW_DW-1:0] rxData
);
  logic [UW_DW-1:0] txHold;
  logic [UW_DW-1:0] txSh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txHold <= '0;
      txSh   <= '0;
      sdo    <= 1'b0;
      sclk   <= 1'b0;
      rxData <= '0;
    end else begin
      if (txWrite) txHold <= txWdata;

      if (strobe.loadTx) begin
        if (strobe.preload) begin
          sdo  <= txHold[UW_DW-1];
          txSh <= {txHold[UW_DW-2:0], 1'b0};
        end else begin
          txSh <= txHold;
        end
      end else if (strobe.driveBit) begin
        sdo  <= txSh[UW_DW-1];
        txSh <= {txSh[UW_DW-2:0], 1'b0};
      end

      if (strobe.rxClear)        rxData <= '0;
      else if (strobe.sampleBit) rxData <= {rxData[UW_DW-2:0], sdi};

      if (strobe.clkToggle) sclk <= ~sclk;
      else if (!busy)       sclk <= idleLevel;
    end
  end
endmodule

// File: rtl/uwire_ctrl.sv
module uwire_ctrl
  import uwire_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [UW_AW-1:0]  busAddr,
  input  logic [UW_DW-1:0]  busWdata,
  output uwStrobe_t         strobe,
  output logic              busy,
  output logic              rdy,
  output logic              clkInv,
  output logic [UW_NCS-1:0] csOut,
  output logic [UW_DW-1:0]  regRdata
);
  localparam logic [UW_CNTW-1:0] ONE = UW_CNTW'(1);

  csCfg_t              cfgQ [UW_NCS];
  logic [UW_CSW-1:0]   csIdx;
  logic                csAssert;
  logic [UW_CNTW-1:0]  txCntQ, rxCntQ, txLeft, rxLeft;
  phase_t              phase;
  logic                half;
  logic [1:0]          divCnt, divLim;
  logic                driveLeadQ, sampleLeadQ;

  logic                ctrlHit, launch, edgeNow, rxDone;
  logic [UW_CSW-1:0]   wrCs;
  csCfg_t              newCfg;
  logic [UW_CNTW-1:0]  reqTx, reqRx;
  logic                newDriveLead, newSampleLead;
  logic [1:0]          newDivLim;
  logic                unusedHi;

  function automatic logic [UW_CNTW-1:0] clampCnt(input logic [UW_CNTW-1:0] c);
    return (c > UW_CNTW'(UW_DW)) ? UW_CNTW'(UW_DW) : c;
  endfunction

  assign unusedHi      = ^busWdata[UW_DW-1:B_BUSY];
  assign busy          = (phase != PH_IDLE);
  assign ctrlHit       = busWr && (busAddr == A_CTRL) && !busy;
  assign wrCs          = busWdata[11:10];
  assign newCfg        = cfgQ[wrCs];
  assign reqTx         = clampCnt(busWdata[9:5]);
  assign reqRx         = clampCnt(busWdata[4:0]);
  assign launch        = ctrlHit && busWdata[B_START] && ((reqTx != '0) || (reqRx != '0));
  // leading edge of a bit is rising when the clock idles low
  assign newDriveLead  = newCfg.driveRise ^ clkInv;
  assign newSampleLead = ~(newCfg.sampleFall ^ clkInv);
  assign newDivLim     = (newCfg.divCode == 2'd0) ? 2'd0 :
                         (newCfg.divCode == 2'd1) ? 2'd1 : 2'd3;
  assign edgeNow       = busy && tickEn && (divCnt == divLim);
  assign rxDone        = edgeNow && (phase == PH_RX) && half && (rxLeft == ONE);

  always_comb begin
    strobe         = '0;
    strobe.loadTx  = launch;
    strobe.preload = launch && (reqTx != '0) && !newDriveLead;
    strobe.rxClear = launch && (reqRx != '0);
    if (edgeNow) begin
      strobe.clkToggle = 1'b1;
      if (phase == PH_TX)
        strobe.driveBit = half ? (!driveLeadQ && (txLeft > ONE)) : driveLeadQ;
      if (phase == PH_RX)
        strobe.sampleBit = half ? !sampleLeadQ : sampleLeadQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < UW_NCS; i++) cfgQ[i] <= '0;
      clkInv      <= 1'b0;
      csIdx       <= '0;
      csAssert    <= 1'b0;
      txCntQ      <= '0;
      rxCntQ      <= '0;
      txLeft      <= '0;
      rxLeft      <= '0;
      phase       <= PH_IDLE;
      half        <= 1'b0;
      divCnt      <= '0;
      divLim      <= '0;
      driveLeadQ  <= 1'b0;
      sampleLeadQ <= 1'b0;
      rdy         <= 1'b0;
    end else begin
      if (busWr && (busAddr == A_CLK)) clkInv <= busWdata[0];
      for (int r = 0; r < UW_CFG_REGS; r++) begin
        if (busWr && (busAddr == A_CFG0 + UW_AW'(r))) begin
          cfgQ[2*r]   <= csCfg_t'(busWdata[5:0]);
          cfgQ[2*r+1] <= csCfg_t'(busWdata[11:6]);
        end
      end

      if (rxDone)                                rdy <= 1'b1;
      else if (busRd && (busAddr == A_DATA))     rdy <= 1'b0;

      if (ctrlHit) begin
        csIdx    <= wrCs;
        csAssert <= busWdata[B_ASSERT];
        txCntQ   <= busWdata[9:5];
        rxCntQ   <= busWdata[4:0];
      end

      if (launch) begin
        phase       <= (reqTx != '0) ? PH_TX : PH_RX;
        txLeft      <= reqTx;
        rxLeft      <= reqRx;
        half        <= 1'b0;
        divCnt      <= '0;
        divLim      <= newDivLim;
        driveLeadQ  <= newDriveLead;
        sampleLeadQ <= newSampleLead;
      end else if (busy && tickEn) begin
        if (divCnt == divLim) begin
          divCnt <= '0;
          half   <= ~half;
          if (half) begin
            if (phase == PH_TX) begin
              txLeft <= txLeft - ONE;
              if (txLeft == ONE) phase <= (rxLeft != '0) ? PH_RX : PH_IDLE;
            end else begin
              rxLeft <= rxLeft - ONE;
              if (rxLeft == ONE) phase <= PH_IDLE;
            end
          end
        end else begin
          divCnt <= divCnt + 2'd1;
        end
      end
    end
  end

  for (genvar g = 0; g < UW_NCS; g++) begin : g_cs
    assign csOut[g] = (csAssert && (csIdx == UW_CSW'(g))) ~^ cfgQ[g].csHigh;
  end

  always_comb begin
    regRdata = '0;
    if (busAddr == A_CTRL)
      regRdata = {rdy, busy, 1'b0, csAssert, csIdx, txCntQ, rxCntQ};
    else if (busAddr == A_CLK)
      regRdata = {{(UW_DW-1){1'b0}}, clkInv};
    for (int r = 0; r < UW_CFG_REGS; r++)
      if (busAddr == A_CFG0 + UW_AW'(r))
        regRdata = {4'b0, cfgQ[2*r+1], cfgQ[2*r]};
  end
endmodule

// File: rtl/uwire_master.sv
module uwire_master
  import uwire_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [UW_AW-1:0]  busAddr,
  input  logic [UW_DW-1:0]  busWdata,
  output logic [UW_DW-1:0]  busRdata,
  output logic              sclk,
  output logic              sdo,
  input  logic              sdi,
  output logic [UW_NCS-1:0] csOut
);
  uwStrobe_t        strobe;
  logic             busy, rdy, clkInv;
  logic [UW_DW-1:0] regRdata, rxData;

  uwire_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata),
    .strobe(strobe), .busy(busy), .rdy(rdy), .clkInv(clkInv),
    .csOut(csOut), .regRdata(regRdata)
  );

  uwire_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .txWrite(busWr && (busAddr == A_DATA)), .txWdata(busWdata),
    .idleLevel(clkInv), .busy(busy), .sdi(sdi),
    .sclk(sclk), .sdo(sdo), .rxData(rxData)
  );

  assign busRdata = (busAddr == A_DATA) ? rxData : regRdata;
endmodule

// File: rtl/uwire_master_chk.sv
module uwire_master_chk
  import uwire_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic              busRd,
  input logic [UW_AW-1:0]  busAddr,
  input logic [UW_DW-1:0]  busWdata,
  input logic              sclk,
  input logic              busy,
  input logic              rdy,
  input logic              clkInv,
  input logic [UW_NCS-1:0] csOut
);
  p_busy_after_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == A_CTRL && busWdata[B_START] && busWdata[9:0] != '0 && !busy) |=> busy);

  p_zero_count_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == A_CTRL && busWdata[B_START] && busWdata[9:0] == '0 && !busy) |=> !busy);

  p_busy_write_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == A_CTRL && busy) |=> $stable(csOut));

  p_ready_cleared_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == A_DATA && !busy) |=> !rdy);

  p_idle_clock_level_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy) && $past(clkInv) == clkInv) |-> sclk == clkInv);
endmodule

bind uwire_master uwire_master_chk chk_i (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
  .busWdata(busWdata), .sclk(sclk), .busy(busy), .rdy(rdy), .clkInv(clkInv),
  .csOut(csOut)
);

// File: tb/uwire_master_tb_top.sv
`timescale 1ns/1ps
module uwire_master_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b1;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        sclk, sdo;
  logic        sdi = 1'b0;
  logic [3:0]  csOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  int tickMode = 0;
  int tickCnt = 0;

  // slave model state
  int          edges = 0;
  int          txN = 0;
  int          rxIdx = 0;
  logic [15:0] cap = '0;
  logic [15:0] rxPat = '0;
  bit          sDriveRise = 1'b0;
  bit          sSampleFall = 1'b0;
  logic [5:0]  cfgShadow [4];

  uwire_master dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .sclk(sclk), .sdo(sdo), .sdi(sdi), .csOut(csOut)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tickCnt = (tickCnt == 2) ? 0 : tickCnt + 1;
    tickEn  = (tickMode == 0) ? 1'b1 : (tickCnt == 0);
  end

  always @(sclk) begin
    edges = edges + 1;
    if (edges <= 2 * txN) begin
      if (sclk != sDriveRise) cap = {cap[14:0], sdo};
    end else if (sclk == !sSampleFall) begin
      rxIdx = rxIdx - 1;
      sdi = (rxIdx >= 0) ? rxPat[rxIdx] : 1'b0;
    end
  end

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); #1 busWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(posedge clk); #1 busRd = 1'b0;
  endtask

  task automatic setCfg(input int cs, input logic [5:0] cfg, input bit inv);
    int r;
    cfgShadow[cs] = cfg;
    r = cs / 2;
    busWrite(3'(2 + r), {4'b0, cfgShadow[2*r+1], cfgShadow[2*r]});
    busWrite(3'd4, {15'b0, inv});
    sDriveRise  = cfg[1];
    sSampleFall = cfg[0];
    @(negedge clk); @(negedge clk);
  endtask

  // H = ticks per clock level, 0 when tickEn is sparse (no timing check)
  task automatic doXfer(input int cs, input int txF, input int rxF,
                        input logic [15:0] word, input logic [15:0] pat, input int h);
    int tn, rn, cnt;
    logic [15:0] d, mTx, mRx;
    tn  = (txF > 16) ? 16 : txF;
    rn  = (rxF > 16) ? 16 : rxF;
    mTx = (tn == 16) ? 16'hFFFF : 16'((1 << tn) - 1);
    mRx = (rn == 16) ? 16'hFFFF : 16'((1 << rn) - 1);
    if (tn > 0) busWrite(3'd0, 16'((word & mTx) << (16 - tn)));
    edges = 0; cap = '0; txN = tn; rxPat = pat;
    rxIdx = rn - 1;
    sdi = (rn > 0) ? pat[rn-1] : 1'b0;
    busWrite(3'd1, 16'h3000 | 16'(cs << 10) | 16'(txF << 5) | 16'(rxF));
    cnt = 0;
    busRead(3'd1, d);
    while (d[14] && cnt < 4000) begin
      cnt++;
      busRead(3'd1, d);
    end
    if (h > 0) chkEq("R6,R9 busy cycles", cnt, 2 * (tn + rn) * h);
    chkEq("R6 clock edges", edges, 2 * (tn + rn));
    if (tn > 0) chkEq("R3,R5 sent word", cap & mTx, word & mTx);
    if (rn > 0) begin
      chkEq("R10 ready set", d[15], 1'b1);
      busRead(3'd0, d);
      chkEq("R4,R5 received word", d, pat & mRx);
      busRead(3'd1, d);
      chkEq("R10 ready cleared", d[15], 1'b0);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 190000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [15:0] d;
    for (int i = 0; i < 4; i++) cfgShadow[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(3'd1, d); chkEq("R1 status", d, 16'h0000);
    chkEq("R1 selects", csOut, 4'hF);
    chkEq("R1 sclk", sclk, 1'b0);
    busRead(3'd4, d); chkEq("R1 inversion reg", d, 16'h0000);

    // R2 packing and readback
    busWrite(3'd2, 16'h0A5C); busWrite(3'd3, 16'hF3C1);
    busRead(3'd2, d); chkEq("R2 cfg pair 0/1", d, 16'h0A5C);
    busRead(3'd3, d); chkEq("R2 cfg pair 2/3", d, 16'h03C1);
    busWrite(3'd1, 16'h18E3);
    busRead(3'd1, d); chkEq("R2 control readback", d, 16'h18E3);
    chkEq("R2,R8 packed polarity", csOut, 4'b0010);
    busWrite(3'd2, 16'h0000); busWrite(3'd3, 16'h0000); busWrite(3'd1, 16'h0000);
    chkEq("R8 all deasserted", csOut, 4'hF);

    // R7 idle level
    busWrite(3'd4, 16'h0001); @(negedge clk); @(negedge clk);
    chkEq("R7 idle high", sclk, 1'b1);
    busRead(3'd4, d); chkEq("R7 inversion readback", d, 16'h0001);
    busWrite(3'd4, 16'h0000); @(negedge clk); @(negedge clk);
    chkEq("R7 idle low", sclk, 1'b0);

    // R8 polarity and deassert
    setCfg(2, 6'h04, 1'b0);
    chkEq("R8 high-active idle", csOut, 4'b1011);
    busWrite(3'd1, 16'h1800); chkEq("R8 assert sel2", csOut, 4'b1111);
    busWrite(3'd1, 16'h1400); chkEq("R8 assert sel1", csOut, 4'b1001);
    busWrite(3'd1, 16'h0400); chkEq("R8 deassert", csOut, 4'b1011);
    setCfg(2, 6'h00, 1'b0);

    // R11 zero-count start
    edges = 0;
    busWrite(3'd1, 16'h3000);
    busRead(3'd1, d);
    chkEq("R11 no busy", d[14], 1'b0);
    chkEq("R11 select asserted", csOut, 4'hE);
    repeat (4) @(negedge clk);
    chkEq("R11 no edges", edges, 0);

    // Sweep: edges, inversion, divide, counts both ways
    for (int mode = 0; mode < 4; mode++)
      for (int inv = 0; inv < 2; inv++)
        for (int dv = 0; dv < 3; dv++) begin
          int cs;
          cs = (mode + dv) % 4;
          setCfg(cs, {1'b0, 2'(dv), 1'b0, 2'(mode)}, 1'(inv));
          for (int n = 1; n <= 16; n++) begin
            logic [15:0] w;
            w = 16'(n * 16'h3A5B + mode * 16'h0111 + inv * 16'h0077 + dv * 16'h01F1);
            doXfer(cs, n, 0, w, 16'h0, 1 << dv);
            doXfer(cs, 0, n, 16'h0, ~w ^ 16'h5A5A, 1 << dv);
          end
        end

    // R12 transmit then receive, and clamping
    setCfg(1, 6'h0A, 1'b1);
    doXfer(1, 8, 12, 16'h00C3, 16'h0B6D, 2);
    doXfer(1, 31, 0, 16'hD00F, 16'h0, 2);
    doXfer(1, 0, 20, 16'h0, 16'h8E71, 2);
    doXfer(1, 20, 5, 16'h1234, 16'h0013, 2);

    // R9 control write during busy is ignored
    setCfg(0, 6'h10, 1'b0);
    busWrite(3'd0, 16'hBEEF);
    edges = 0; cap = '0; txN = 16;
    busWrite(3'd1, 16'h3000 | 16'(16 << 5));
    busWrite(3'd1, 16'h3C00 | 16'(5 << 5));
    busRead(3'd1, d);
    while (d[14]) busRead(3'd1, d);
    chkEq("R9 edges unchanged", edges, 32);
    chkEq("R9 data unchanged", cap, 16'hBEEF);
    chkEq("R9 select unchanged", csOut, 4'hE);
    chkEq("R9 index unchanged", d[11:10], 2'd0);

    // sparse base tick
    tickMode = 1;
    setCfg(3, 6'h03, 1'b1);
    doXfer(3, 12, 0, 16'h0A5B, 16'h0, 0);
    doXfer(3, 0, 9, 16'h0, 16'h0135, 0);
    tickMode = 0;

    finishRun();
  end
endmodule